// File: doc/BRIEF.md
# Dual-Slot Instruction Pairing Fill Unit

This block sits between an instruction decoder and a cache whose entries each hold two instruction slots. It takes decoded instructions one at a time, each carrying an operation class, a source register and a destination register. It packs them in program order into slot A and slot B of an entry. Each slot feeds its own execution pipeline. Slot A's pipeline runs integer and floating-point work, and slot B's pipeline runs integer and load work. An integer instruction may therefore sit in either slot, a floating-point instruction only in slot A, and a load only in slot B.

The fill unit checks the dependency between the two members of a pair once, when it writes the entry. It records the result as a single independence bit. The issue stage reads that bit and sends the pair to both pipelines in one cycle when it is set. When it is clear, the issue stage sends the two instructions over two cycles, each still to its own slot's pipeline. An instruction that finds no partner it may legally share an entry with occupies an entry alone, and the unused slot is marked empty. A flush request writes out a half-filled entry.

Top module: `pairfill_top`

## Requirements
- R1: After reset, wrValid is 0, wrSlotValid is 2'b00, all slot fields are zero, and no instruction is held.
- R2: inReady equals the inverse of flush, and an instruction is taken only in a cycle where inValid and inReady are both 1. Class codes: 2'b00 integer, 2'b01 load, 2'b10 floating point, and 2'b11 handled as integer.
- R3: An integer or floating-point instruction taken while no instruction is held becomes the held slot-A instruction and produces no write.
- R4: An integer or load instruction taken while an instruction is held completes a pair. In the cycle after it is taken, wrValid is 1, wrSlotValid is 2'b11, slot A carries the held instruction and slot B the new one.
- R5: For a pair, wrIndep is 1 exactly when slot B's source differs from slot A's destination (no read-after-write) and slot B's destination differs from slot A's destination (no write-after-write).
- R6: A floating-point instruction taken while an instruction is held writes the held instruction alone, with wrSlotValid 2'b01, in the next cycle. The floating-point instruction becomes the new held instruction.
- R7: A load taken while nothing is held is written alone in slot B, with wrSlotValid 2'b10, in the next cycle.
- R8: A flush with an instruction held writes that instruction alone in slot A in the next cycle and leaves nothing held. A flush with nothing held produces no write. Input presented during a flush is ignored.
- R9: wrIndep is 0 for every entry with only one valid slot. The fields of an empty slot, and all fields in a cycle without a write, are zero.
- R10: Slot A never carries a load and slot B never carries a floating-point instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Write out any half-filled entry and drop pending input |
| inValid | input | 1 | Decoded instruction present |
| inReady | output | 1 | Fill unit accepts an instruction this cycle |
| inCls | input | 2 | Operation class of the incoming instruction |
| inSrc | input | REG_W | Source register of the incoming instruction |
| inDst | input | REG_W | Destination register of the incoming instruction |
| wrValid | output | 1 | One-cycle strobe: entry write this cycle |
| wrSlotValid | output | 2 | Bit 0 marks slot A valid, bit 1 marks slot B valid |
| wrIndep | output | 1 | Pair may issue to both pipelines together |
| wrACls | output | 2 | Slot A class |
| wrASrc | output | REG_W | Slot A source register |
| wrADst | output | REG_W | Slot A destination register |
| wrBCls | output | 2 | Slot B class |
| wrBSrc | output | REG_W | Slot B source register |
| wrBDst | output | REG_W | Slot B destination register |

## Verification
On every cycle the assertions check several properties. The slot-valid field agrees with the write strobe, and the independence bit appears only on full pairs and is consistent with the written register numbers. No class lands in the wrong slot's pipeline, and a flush always empties the held slot. Only the bench scenarios can show that program order is kept, meaning the held instruction really lands in slot A alongside the correct follower. The same holds for the correct outcome of each class sequence: floating-point after floating-point, load into an empty entry, and flush with or without a held instruction. These scenarios also show that input offered during a flush leaves no trace.

// File: rtl/pairfill_pkg.sv
package pairfill_pkg;
  parameter int REG_W = 5;
  localparam int CLS_W = 2;

  localparam logic [CLS_W-1:0] CLS_INT  = 2'b00;
  localparam logic [CLS_W-1:0] CLS_LOAD = 2'b01;
  localparam logic [CLS_W-1:0] CLS_FP   = 2'b10;

  typedef struct packed {
    logic [CLS_W-1:0] cls;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
  } instr_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdA;     // capture incoming into held slot-A register
    logic emitA;     // write held instruction alone in slot A
    logic emitPair;  // write held + incoming as a pair
    logic emitB;     // write incoming alone in slot B
  } strobe_t;
endpackage

// File: rtl/pairfill_ctrl.sv
module pairfill_ctrl
  import pairfill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [CLS_W-1:0] inCls,
  output logic             inReady,
  output strobe_t          stb
);
  logic pendQ, pendD;
  logic take, isLoad, isFp;

  assign inReady = !flush;
  assign take    = inValid && inReady;
  assign isLoad  = (inCls == CLS_LOAD);
  assign isFp    = (inCls == CLS_FP);

  always_comb begin
    stb   = '0;
    pendD = pendQ;
    if (flush) begin
      stb.emitA = pendQ;
      pendD     = 1'b0;
    end else if (take) begin
      if (!pendQ) begin
        if (isLoad) begin
          stb.emitB = 1'b1;
        end else begin
          stb.holdA = 1'b1;
          pendD     = 1'b1;
        end
      end else if (isFp) begin
        stb.emitA = 1'b1;
        stb.holdA = 1'b1;
      end else begin
        stb.emitPair = 1'b1;
        pendD        = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= pendD;
  end

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !pendQ);
  assert_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady != flush);
  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.emitA, stb.emitPair, stb.emitB}));
  assert_pair_needs_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emitPair || stb.emitA) |-> pendQ);
endmodule

// File: rtl/pairfill_dp.sv
module pairfill_dp
  import pairfill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  instr_t           inInstr,
  output logic             wrValid,
  output logic [1:0]       wrSlotValid,
  output logic             wrIndep,
  output instr_t           wrA,
  output instr_t           wrB
);
  instr_t heldA;
  logic   rawHit, wawHit;

  assign rawHit = (inInstr.src == heldA.dst);
  assign wawHit = (inInstr.dst == heldA.dst);

  always_ff @(posedge clk) begin
    if (!rstN) heldA <= '0;
    else if (stb.holdA) heldA <= inInstr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid     <= 1'b0;
      wrSlotValid <= 2'b00;
      wrIndep     <= 1'b0;
      wrA         <= '0;
      wrB         <= '0;
    end else begin
      wrValid     <= stb.emitA || stb.emitPair || stb.emitB;
      wrSlotValid <= 2'b00;
      wrIndep     <= 1'b0;
      wrA         <= '0;
      wrB         <= '0;
      if (stb.emitPair) begin
        wrSlotValid <= 2'b11;
        wrIndep     <= !(rawHit || wawHit);
        wrA         <= heldA;
        wrB         <= inInstr;
      end else if (stb.emitA) begin
        wrSlotValid <= 2'b01;
        wrA         <= heldA;
      end else if (stb.emitB) begin
        wrSlotValid <= 2'b10;
        wrB         <= inInstr;
      end
    end
  end

  assert_slots_match_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid == (wrSlotValid != 2'b00));
  assert_indep_only_pairs_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrIndep |-> (wrSlotValid == 2'b11));
  assert_indep_clean_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrIndep |-> (wrB.src != wrA.dst && wrB.dst != wrA.dst));
  assert_dep_real_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrSlotValid == 2'b11 && !wrIndep) |-> (wrB.src == wrA.dst || wrB.dst == wrA.dst));
  assert_slot_a_class_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrSlotValid[0] |-> (wrA.cls != CLS_LOAD));
  assert_slot_b_class_R10: assert property (@(posedge clk) disable iff (!rstN)
    wrSlotValid[1] |-> (wrB.cls != CLS_FP));
endmodule

// File: rtl/pairfill_top.sv
module pairfill_top
  import pairfill_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  output logic             inReady,
  input  logic [CLS_W-1:0] inCls,
  input  logic [REG_W-1:0] inSrc,
  input  logic [REG_W-1:0] inDst,
  output logic             wrValid,
  output logic [1:0]       wrSlotValid,
  output logic             wrIndep,
  output logic [CLS_W-1:0] wrACls,
  output logic [REG_W-1:0] wrASrc,
  output logic [REG_W-1:0] wrADst,
  output logic [CLS_W-1:0] wrBCls,
  output logic [REG_W-1:0] wrBSrc,
  output logic [REG_W-1:0] wrBDst
);
  strobe_t stb;
  instr_t  inInstr, wrA, wrB;

  assign inInstr = '{cls: inCls, src: inSrc, dst: inDst};

  pairfill_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid),
    .inCls(inCls), .inReady(inReady), .stb(stb)
  );

  pairfill_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .inInstr(inInstr),
    .wrValid(wrValid), .wrSlotValid(wrSlotValid), .wrIndep(wrIndep),
    .wrA(wrA), .wrB(wrB)
  );

  assign wrACls = wrA.cls;
  assign wrASrc = wrA.src;
  assign wrADst = wrA.dst;
  assign wrBCls = wrB.cls;
  assign wrBSrc = wrB.src;
  assign wrBDst = wrB.dst;
endmodule

// File: tb/pairfill_top_tb_top.sv
`timescale 1ns/1ps
module pairfill_top_tb_top;
  localparam int RW = 5;
  logic clk = 1'b0, rstN = 1'b0, flush = 1'b0, inValid = 1'b0;
  logic [1:0] inCls = '0;
  logic [RW-1:0] inSrc = '0, inDst = '0;
  logic inReady, wrValid, wrIndep;
  logic [1:0] wrSlotValid, wrACls, wrBCls;
  logic [RW-1:0] wrASrc, wrADst, wrBSrc, wrBDst;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench reference state
  bit pendV = 1'b0;
  logic [1:0] pCls = '0;
  logic [RW-1:0] pSrc = '0, pDst = '0;
  // expected outputs: {wv, sv, ind, aCls, aSrc, aDst, bCls, bSrc, bDst}
  logic [2+1+1+3*(2+2*RW)-1:0] expV;

  always #2 clk = ~clk;

  pairfill_top dut_i (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inCls(inCls), .inSrc(inSrc), .inDst(inDst), .wrValid(wrValid),
    .wrSlotValid(wrSlotValid), .wrIndep(wrIndep), .wrACls(wrACls), .wrASrc(wrASrc),
    .wrADst(wrADst), .wrBCls(wrBCls), .wrBSrc(wrBSrc), .wrBDst(wrBDst)
  );

  function automatic logic [2+1+1+3*(2+2*RW)-1:0] pack(
      bit wv, logic [1:0] sv, bit ind, logic [1:0] ac, logic [RW-1:0] as_, ad,
      logic [1:0] bc, logic [RW-1:0] bs, bd);
    return {wv, sv, ind, ac, as_, ad, bc, bs, bd, {(2+2*RW){1'b0}}};
  endfunction

  function automatic bit depends(logic [RW-1:0] aDst, bSrc, bDst);
    return (bSrc == aDst) || (bDst == aDst);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model, then compare after the next edge
  task automatic cycle(input bit fl, v, input logic [1:0] c,
                       input logic [RW-1:0] s, d, input string forceTag);
    string tag;
    logic [2+1+1+3*(2+2*RW)-1:0] got;
    bit take, isLd, isFp;
    flush = fl; inValid = v; inCls = c; inSrc = s; inDst = d;
    #1;
    check(inReady == !fl, "R2", "inReady", 64'(inReady), 64'(!fl));
    take = v && !fl;
    isLd = (c == 2'b01);
    isFp = (c == 2'b10);
    expV = '0; tag = "R3";
    if (fl) begin
      tag = "R8";
      if (pendV) expV = pack(1, 2'b01, 0, pCls, pSrc, pDst, 0, 0, 0);
      pendV = 0;
    end else if (take) begin
      if (!pendV) begin
        if (isLd) begin
          tag = "R7";
          expV = pack(1, 2'b10, 0, 0, 0, 0, c, s, d);
        end else begin
          pendV = 1; pCls = c; pSrc = s; pDst = d;
        end
      end else if (isFp) begin
        tag = "R6";
        expV = pack(1, 2'b01, 0, pCls, pSrc, pDst, 0, 0, 0);
        pCls = c; pSrc = s; pDst = d;
      end else begin
        tag = "R4";
        expV = pack(1, 2'b11, !depends(pDst, s, d), pCls, pSrc, pDst, c, s, d);
        pendV = 0;
      end
    end
    if (forceTag != "") tag = forceTag;
    @(posedge clk);
    @(negedge clk);
    got = pack(wrValid, wrSlotValid, wrIndep, wrACls, wrASrc, wrADst, wrBCls, wrBSrc, wrBDst);
    check(got == expV, tag, "entry", 64'(got), 64'(expV));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0;
    // R1: reset state
    check({wrValid, wrSlotValid, wrIndep} == 4'b0, "R1", "reset strobes",
          64'({wrValid, wrSlotValid, wrIndep}), 64'h0);
    check({wrASrc, wrADst, wrBSrc, wrBDst} == '0, "R1", "reset fields",
          64'({wrASrc, wrADst, wrBSrc, wrBDst}), 64'h0);

    // R3 then R4 independent pair of integers
    cycle(0, 1, 2'b00, 5'd1, 5'd2, "R3");
    cycle(0, 1, 2'b00, 5'd3, 5'd4, "R4");
    // R5 read-after-write dependence
    cycle(0, 1, 2'b00, 5'd1, 5'd7, "R3");
    cycle(0, 1, 2'b01, 5'd7, 5'd9, "R5");
    // R5 write-after-write dependence
    cycle(0, 1, 2'b10, 5'd2, 5'd6, "R3");
    cycle(0, 1, 2'b00, 5'd3, 5'd6, "R5");
    // R6 fp after fp, then code 3 handled as integer pairs (R2)
    cycle(0, 1, 2'b10, 5'd1, 5'd8, "R3");
    cycle(0, 1, 2'b10, 5'd2, 5'd9, "R6");
    cycle(0, 1, 2'b11, 5'd4, 5'd5, "R2");
    // R7 load into empty entry
    cycle(0, 1, 2'b01, 5'd10, 5'd11, "R7");
    // R8 flush with held instruction, input ignored during flush
    cycle(0, 1, 2'b00, 5'd12, 5'd13, "R3");
    cycle(1, 1, 2'b01, 5'd14, 5'd15, "R8");
    // R8 flush with nothing held
    cycle(1, 1, 2'b00, 5'd16, 5'd17, "R8");
    // R9 idle cycle: no write, zero fields
    cycle(0, 0, 2'b01, 5'd18, 5'd19, "R9");
    // R10 load behind held fp goes to slot B with fp in A
    cycle(0, 1, 2'b10, 5'd20, 5'd21, "R3");
    cycle(0, 1, 2'b01, 5'd22, 5'd23, "R10");

    // constrained random: small register range to hit dependences
    for (int i = 0; i < 1500; i++) begin
      bit fl, v;
      fl = ($urandom % 16) == 0;
      v  = ($urandom % 4) != 0;
      cycle(fl, v, 2'($urandom % 4), 5'($urandom % 4), 5'($urandom % 4), "");
    end
    cycle(1, 0, 2'b00, 5'd0, 5'd0, "R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule